// File: doc/BRIEF.md
# Background Tile Fetch Pipeline

This block produces the background layer of a tile-based raster video unit, one dot per clock. An external timing generator supplies the scanline number (0 to 261) and the dot number within the line (0 to 340). During each 8-dot group of the drawing region, and during two extra groups near the end of each line, the block reads four bytes from video memory: the tile number from the name table, the palette attribute for that tile, and the low and high bitplanes of the current tile row from the pattern table.

Finished tile rows go into 16-bit shift planes. The fine horizontal scroll value picks which tap of those planes drives the output, so every dot yields a 2-bit colour index and a 2-bit palette select. The block holds the live scroll address. It steps that address horizontally after every group and vertically at the end of the drawing region. It reloads the horizontal fields from the programmed scroll address after the drawing region, and reloads the vertical fields late in the pre-render line. Sprite handling and colour lookup belong to other blocks.

Top module: `bgTilePipe`

## Requirements
- R1: While reset is held and just after it is released, the live scroll address output is 0, the pixel index and palette select are 0, and no memory read is issued while rendering is disabled.
- R2: The live scroll address holds coarse X in bits 4:0, coarse Y in bits 9:5, the horizontal table select in bit 10, the vertical table select in bit 11 and fine Y in bits 14:12. On visible lines (0 to 239) and the pre-render line (261), each 8-dot group starting at dots 1, 9, ..., 249, 321 and 329 issues four reads. At group offset 0 it reads the name table at 0x2000 | addr[11:0]. At offset 2 it reads the attribute at 0x23C0 | tableSelect<<10 | (coarseY>>2)<<3 | (coarseX>>2). At offset 4 it reads the low plane at patSel*0x1000 + tile*16 + fineY. At offset 6 it reads the high plane at that address + 8. The read strobe is high only on those dots.
- R3: On a visible line, the pixel index at dot x (1 to 256) is {high bit, low bit}. The bits are taken from tile k = (x-1+fineX)/8, counting the first tile read at dot 321 of the previous line as k=0, at bit position 7-((x-1+fineX) mod 8).
- R4: Coarse X rises by one at the end of each fetch group. Stepping from 31 returns it to 0 and inverts bit 10.
- R5: At the end of dot 256 on an active line, fine Y rises by one. Stepping from 7 clears it and steps coarse Y. Coarse Y 29 wraps to 0 and inverts bit 11. Coarse Y 31 wraps to 0 with bit 11 unchanged.
- R6: At the end of dot 257 on an active line, bits 10 and 4:0 of the live address are copied from the programmed scroll address.
- R7: On the pre-render line, during dots 280 to 304, bits 14:11 and 9:5 are copied from the programmed scroll address.
- R8: The pixel index and palette select are 0 at dot 0 and at dots 257 to 340, and on lines 240 to 261. No reads are issued and the live address does not change on lines 240 to 260.
- R9: With rendering disabled, no reads are issued, the live address is held, and the pixel outputs stay 0.
- R10: The palette select at dot x is two bits of the attribute byte for tile k, taken from the bit position 4*coarseY[1] + 2*coarseX[1] of that tile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low synchronous reset |
| renderEn | input | 1 | Background rendering enable |
| scanline | input | 9 | Current line number, 0 to 261 |
| cycle | input | 9 | Current dot within the line, 0 to 340 |
| tAddr | input | 15 | Programmed scroll address, same field layout as the live address |
| fineX | input | 3 | Fine horizontal scroll, selects the shifter tap |
| patSel | input | 1 | Selects the upper or lower 4 KB pattern half |
| memData | input | 8 | Read data for the address presented this dot |
| memAddr | output | 14 | Video memory read address |
| memRd | output | 1 | Read strobe |
| vAddr | output | 15 | Live scroll address |
| pixIdx | output | 2 | Background colour index per dot |
| palSel | output | 2 | Background palette select per dot |

## Verification
Three scroll setups drive a pre-render line followed by the first visible line. Against a memory whose contents depend on the address, all 256 dots are compared with an index and palette computed from the requirement formulas. The first setup has no fine scroll and a mid-table column. It separates correct tap and load timing from an off-by-one shift. The second starts at column 30 with fine scroll 5 and fine Y 7 on coarse row 29. It crosses the horizontal table boundary and exercises the row 29 wrap that inverts the table bit. The third uses row 31 and fine scroll 7. It separates that wrap from the row 29 case and stresses the last tap. Separate runs with rendering disabled and on an idle line show that reads, address stepping and pixels all stop.

// File: rtl/bgPipePkg.sv
package bgPipePkg;
  localparam int ADDR_W   = 14;
  localparam int SCROLL_W = 15;
  localparam int BYTE_W   = 8;
  localparam int SHIFT_W  = 2 * BYTE_W;
  localparam int PLANES   = 4;

  typedef struct packed {
    logic fetchNt;
    logic fetchAt;
    logic fetchLo;
    logic fetchHi;
    logic incX;
    logic incY;
    logic copyH;
    logic copyV;
    logic shiftEn;
    logic loadEn;
    logic pixOn;
  } bgStrobeT;
endpackage

// File: rtl/bgCtrl.sv
module bgCtrl
  import bgPipePkg::*;
#(
  parameter int CNT_W          = 9,
  parameter int FRAME_LINES    = 262,
  parameter int VIS_LINES      = 240,
  parameter int VIS_DOTS       = 256,
  parameter int PREFETCH_START = 321,
  parameter int PREFETCH_TILES = 2,
  parameter int VCOPY_FIRST    = 280,
  parameter int VCOPY_LAST     = 304
) (
  input  logic             renderEn,
  input  logic [CNT_W-1:0] scanline,
  input  logic [CNT_W-1:0] cycle,
  output bgStrobeT         stb
);
  localparam logic [CNT_W-1:0] PRE_LINE   = CNT_W'(FRAME_LINES - 1);
  localparam logic [CNT_W-1:0] VIS_LAST   = CNT_W'(VIS_LINES - 1);
  localparam logic [CNT_W-1:0] DRAW_LAST  = CNT_W'(VIS_DOTS);
  localparam logic [CNT_W-1:0] HCOPY_DOT  = CNT_W'(VIS_DOTS + 1);
  localparam logic [CNT_W-1:0] PF_FIRST   = CNT_W'(PREFETCH_START);
  localparam logic [CNT_W-1:0] PF_LAST    = CNT_W'(PREFETCH_START + 8 * PREFETCH_TILES - 1);
  localparam logic [CNT_W-1:0] VC_FIRST   = CNT_W'(VCOPY_FIRST);
  localparam logic [CNT_W-1:0] VC_LAST    = CNT_W'(VCOPY_LAST);
  localparam logic [CNT_W-1:0] DOT_ONE    = CNT_W'(1);

  logic visLine, preLine, activeLine, inDraw, inPrefetch, fetchWin;
  logic [2:0] phase;

  always_comb begin
    visLine    = scanline <= VIS_LAST;
    preLine    = scanline == PRE_LINE;
    activeLine = renderEn && (visLine || preLine);
    inDraw     = (cycle >= DOT_ONE) && (cycle <= DRAW_LAST);
    inPrefetch = (cycle >= PF_FIRST) && (cycle <= PF_LAST);
    fetchWin   = activeLine && (inDraw || inPrefetch);
    phase      = cycle[2:0];

    stb.fetchNt = fetchWin && (phase == 3'd1);
    stb.fetchAt = fetchWin && (phase == 3'd3);
    stb.fetchLo = fetchWin && (phase == 3'd5);
    stb.fetchHi = fetchWin && (phase == 3'd7);
    stb.incX    = fetchWin && (phase == 3'd0);
    stb.loadEn  = fetchWin && (phase == 3'd0);
    stb.shiftEn = fetchWin;
    stb.incY    = activeLine && (cycle == DRAW_LAST);
    stb.copyH   = activeLine && (cycle == HCOPY_DOT);
    stb.copyV   = renderEn && preLine && (cycle >= VC_FIRST) && (cycle <= VC_LAST);
    stb.pixOn   = renderEn && visLine && inDraw;
  end
endmodule

// File: rtl/bgData.sv
module bgData
  import bgPipePkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  bgStrobeT            stb,
  input  logic [SCROLL_W-1:0] tAddr,
  input  logic [2:0]          fineX,
  input  logic                patSel,
  input  logic [BYTE_W-1:0]   memData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRd,
  output logic [SCROLL_W-1:0] vAddr,
  output logic [1:0]          pixIdx,
  output logic [1:0]          palSel
);
  logic [SCROLL_W-1:0] vReg, vNext;
  logic [BYTE_W-1:0]   ntLatch, loLatch, hiLatch, atShifted;
  logic [1:0]          atLatch, atSel;
  logic [4:0]          coarseX, coarseY;
  logic [2:0]          fineY;
  logic [1:0]          tblSel;
  logic [3:0]          tap;

  logic [SHIFT_W-1:0]  planeSh   [PLANES];
  logic [BYTE_W-1:0]   planeLoad [PLANES];
  logic [PLANES-1:0]   planeTap;

  assign coarseX = vReg[4:0];
  assign coarseY = vReg[9:5];
  assign tblSel  = vReg[11:10];
  assign fineY   = vReg[14:12];
  assign vAddr   = vReg;

  // address selection for the four reads of a group
  always_comb begin
    memAddr = '0;
    if (stb.fetchNt)      memAddr = {2'b10, vReg[11:0]};
    else if (stb.fetchAt) memAddr = {2'b10, tblSel, 4'b1111, coarseY[4:2], coarseX[4:2]};
    else if (stb.fetchLo) memAddr = {1'b0, patSel, ntLatch, 1'b0, fineY};
    else if (stb.fetchHi) memAddr = {1'b0, patSel, ntLatch, 1'b1, fineY};
    memRd = stb.fetchNt | stb.fetchAt | stb.fetchLo | stb.fetchHi;
  end

  assign atShifted = memData >> {coarseY[1], coarseX[1], 1'b0};
  assign atSel     = atShifted[1:0];

  // scroll address stepping and reloads
  always_comb begin
    vNext = vReg;
    if (stb.incX) begin
      if (vNext[4:0] == 5'd31) begin
        vNext[4:0] = 5'd0;
        vNext[10]  = ~vNext[10];
      end else begin
        vNext[4:0] = vNext[4:0] + 5'd1;
      end
    end
    if (stb.incY) begin
      if (vNext[14:12] != 3'd7) begin
        vNext[14:12] = vNext[14:12] + 3'd1;
      end else begin
        vNext[14:12] = 3'd0;
        if (vNext[9:5] == 5'd29) begin
          vNext[9:5] = 5'd0;
          vNext[11]  = ~vNext[11];
        end else if (vNext[9:5] == 5'd31) begin
          vNext[9:5] = 5'd0;
        end else begin
          vNext[9:5] = vNext[9:5] + 5'd1;
        end
      end
    end
    if (stb.copyH) begin
      vNext[10]  = tAddr[10];
      vNext[4:0] = tAddr[4:0];
    end
    if (stb.copyV) begin
      vNext[14:11] = tAddr[14:11];
      vNext[9:5]   = tAddr[9:5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vReg    <= '0;
      ntLatch <= '0;
      loLatch <= '0;
      hiLatch <= '0;
      atLatch <= '0;
    end else begin
      vReg <= vNext;
      if (stb.fetchNt) ntLatch <= memData;
      if (stb.fetchAt) atLatch <= atSel;
      if (stb.fetchLo) loLatch <= memData;
      if (stb.fetchHi) hiLatch <= memData;
    end
  end

  assign planeLoad[0] = loLatch;
  assign planeLoad[1] = hiLatch;
  assign planeLoad[2] = {BYTE_W{atLatch[0]}};
  assign planeLoad[3] = {BYTE_W{atLatch[1]}};

  assign tap = 4'(SHIFT_W - 1) - {1'b0, fineX};

  for (genvar p = 0; p < PLANES; p++) begin : gPlane
    logic [SHIFT_W-1:0] shNext;
    always_comb begin
      shNext = stb.shiftEn ? {planeSh[p][SHIFT_W-2:0], 1'b0} : planeSh[p];
      if (stb.loadEn) shNext[BYTE_W-1:0] = planeLoad[p];
    end
    always_ff @(posedge clk) begin
      if (!rstN) planeSh[p] <= '0;
      else       planeSh[p] <= shNext;
    end
    assign planeTap[p] = planeSh[p][tap];
  end

  assign pixIdx = stb.pixOn ? planeTap[1:0] : 2'b00;
  assign palSel = stb.pixOn ? planeTap[3:2] : 2'b00;

  p_hcopy_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyH |=> (vReg[4:0] == $past(tAddr[4:0])) && (vReg[10] == $past(tAddr[10])));

  p_vcopy_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyV |=> (vReg[14:11] == $past(tAddr[14:11])) && (vReg[9:5] == $past(tAddr[9:5])));

  p_step_x_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incX && !stb.incY && vReg[4:0] != 5'd31) |=> vReg[4:0] == $past(vReg[4:0]) + 5'd1);

  p_wrap_x_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incX && !stb.incY && vReg[4:0] == 5'd31) |=> (vReg[4:0] == 5'd0) && (vReg[10] != $past(vReg[10])));

  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadEn |=> (planeSh[0][BYTE_W-1:0] == $past(loLatch)) && (planeSh[1][BYTE_W-1:0] == $past(hiLatch)));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.shiftEn && !stb.incY && !stb.copyH && !stb.copyV) |=> $stable(vReg));
endmodule

// File: rtl/bgTilePipe.sv
module bgTilePipe
  import bgPipePkg::*;
#(
  parameter int CNT_W          = 9,
  parameter int FRAME_LINES    = 262,
  parameter int VIS_LINES      = 240,
  parameter int VIS_DOTS       = 256,
  parameter int PREFETCH_START = 321,
  parameter int PREFETCH_TILES = 2,
  parameter int VCOPY_FIRST    = 280,
  parameter int VCOPY_LAST     = 304
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                renderEn,
  input  logic [CNT_W-1:0]    scanline,
  input  logic [CNT_W-1:0]    cycle,
  input  logic [SCROLL_W-1:0] tAddr,
  input  logic [2:0]          fineX,
  input  logic                patSel,
  input  logic [BYTE_W-1:0]   memData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRd,
  output logic [SCROLL_W-1:0] vAddr,
  output logic [1:0]          pixIdx,
  output logic [1:0]          palSel
);
  bgStrobeT stb;

  bgCtrl #(
    .CNT_W(CNT_W), .FRAME_LINES(FRAME_LINES), .VIS_LINES(VIS_LINES),
    .VIS_DOTS(VIS_DOTS), .PREFETCH_START(PREFETCH_START),
    .PREFETCH_TILES(PREFETCH_TILES), .VCOPY_FIRST(VCOPY_FIRST),
    .VCOPY_LAST(VCOPY_LAST)
  ) ctrl_i (
    .renderEn(renderEn), .scanline(scanline), .cycle(cycle), .stb(stb)
  );

  bgData data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .tAddr(tAddr), .fineX(fineX),
    .patSel(patSel), .memData(memData), .memAddr(memAddr), .memRd(memRd),
    .vAddr(vAddr), .pixIdx(pixIdx), .palSel(palSel)
  );

  p_idle_lines_r8: assert property (@(posedge clk) disable iff (!rstN)
    (scanline >= CNT_W'(VIS_LINES) && scanline < CNT_W'(FRAME_LINES - 1)) |-> (!memRd && pixIdx == 2'b00));

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !renderEn |-> (!memRd && pixIdx == 2'b00 && palSel == 2'b00));
endmodule

// File: tb/bgTilePipe_tb.sv
`timescale 1ns/1ps
module bgTilePipe_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        renderEn = 1'b0;
  logic [8:0]  scanline = '0;
  logic [8:0]  cycle = '0;
  logic [14:0] tAddr = '0;
  logic [2:0]  fineX = '0;
  logic        patSel = 1'b0;
  logic [7:0]  memData;
  logic [13:0] memAddr;
  logic        memRd;
  logic [14:0] vAddr;
  logic [1:0]  pixIdx, palSel;

  int nChk = 0;
  int nBad = 0;

  logic [1:0]  capPix [0:340];
  logic [1:0]  capPal [0:340];
  logic [13:0] capAddr[0:340];
  logic        capRd  [0:340];
  logic [14:0] capV   [0:340];

  always #2.5 clk = ~clk;

  bgTilePipe dut_i (
    .clk(clk), .rstN(rstN), .renderEn(renderEn), .scanline(scanline),
    .cycle(cycle), .tAddr(tAddr), .fineX(fineX), .patSel(patSel),
    .memData(memData), .memAddr(memAddr), .memRd(memRd), .vAddr(vAddr),
    .pixIdx(pixIdx), .palSel(palSel)
  );

  function automatic logic [7:0] memFn(input logic [13:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ {a[13:7], 1'b1};
  endfunction

  assign memData = memFn(memAddr);

  task automatic chk(input string req, input int act, input int exp, input string what);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runLine(input int line);
    for (int c = 0; c <= 340; c++) begin
      @(posedge clk);
      #1;
      scanline = 9'(line);
      cycle    = 9'(c);
      @(negedge clk);
      capPix[c]  = pixIdx;
      capPal[c]  = palSel;
      capAddr[c] = memAddr;
      capRd[c]   = memRd;
      capV[c]    = vAddr;
    end
  endtask

  function automatic logic [14:0] yStep(input logic [14:0] v);
    logic [14:0] r;
    r = v;
    if (r[14:12] != 3'd7) r[14:12] = r[14:12] + 3'd1;
    else begin
      r[14:12] = 3'd0;
      if (r[9:5] == 5'd29) begin r[9:5] = 5'd0; r[11] = ~r[11]; end
      else if (r[9:5] == 5'd31) r[9:5] = 5'd0;
      else r[9:5] = r[9:5] + 5'd1;
    end
    return r;
  endfunction

  task automatic tReset();
    @(negedge clk);
    chk("R1", int'(vAddr), 0, "vAddr in reset");
    chk("R1", int'(pixIdx), 0, "pixIdx in reset");
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'(vAddr), 0, "vAddr after reset");
    chk("R1", int'(memRd), 0, "memRd after reset");
    chk("R1", int'(palSel), 0, "palSel after reset");
  endtask

  task automatic tScroll(input logic [14:0] tA, input logic [2:0] fx, input logic ps, input string tag);
    logic [14:0] vy;
    int badPix, badPal, badRd;
    renderEn = 1'b1;
    tAddr = tA; fineX = fx; patSel = ps;
    runLine(261);
    chk("R6", int'({capV[258][10], capV[258][4:0]}), int'({tA[10], tA[4:0]}), {tag, " horizontal reload"});
    chk("R7", int'({capV[305][14:11], capV[305][9:5]}), int'({tA[14:11], tA[9:5]}), {tag, " vertical reload"});
    chk("R2", int'(capAddr[321]), int'({2'b10, tA[11:0]}), {tag, " name read at 321"});
    chk("R2", int'(capAddr[323]), int'({2'b10, tA[11:10], 4'b1111, tA[9:7], tA[4:2]}), {tag, " attribute read at 323"});
    chk("R2", int'(capAddr[325]), int'({1'b0, ps, memFn(capAddr[321]), 1'b0, tA[14:12]}), {tag, " low plane read"});
    chk("R2", int'(capAddr[327]), int'({1'b0, ps, memFn(capAddr[321]), 1'b1, tA[14:12]}), {tag, " high plane read"});
    chk("R2", int'(capRd[322]), 0, {tag, " no read at even offset"});
    chk("R8", int'(capPix[100]), 0, {tag, " pre-render line pixel"});
    runLine(0);
    // R4: the third column is read at dot 1 of the line
    begin
      int col5 = int'(tA[4:0]) + 2;
      logic [11:0] nAddr;
      nAddr = {tA[11], tA[10] ^ (col5 >= 32), tA[9:5], 5'(col5 % 32)};
      chk("R4", int'(capAddr[1]), int'({2'b10, nAddr}), {tag, " column step at dot 1"});
    end
    badPix = 0; badPal = 0;
    for (int x = 1; x <= 256; x++) begin
      int k = (x - 1 + int'(fx)) / 8;
      int b = (x - 1 + int'(fx)) % 8;
      int col5 = int'(tA[4:0]) + k;
      logic [4:0]  col;
      logic        ntH;
      logic [7:0]  tile, lo, hi, at;
      logic [1:0]  ePix, ePal;
      col  = 5'(col5 % 32);
      ntH  = tA[10] ^ (col5 >= 32);
      tile = memFn({2'b10, tA[11], ntH, tA[9:5], col});
      lo   = memFn({1'b0, ps, tile, 1'b0, tA[14:12]});
      hi   = memFn({1'b0, ps, tile, 1'b1, tA[14:12]});
      at   = memFn({2'b10, tA[11], ntH, 4'b1111, tA[9:7], col[4:2]});
      ePix = {hi[7-b], lo[7-b]};
      at   = at >> {tA[6], col[1], 1'b0};
      ePal = at[1:0];
      if (capPix[x] != ePix) begin
        badPix++;
        if (badPix == 1) chk("R3", int'(capPix[x]), int'(ePix), $sformatf("%s first pixel mismatch dot %0d", tag, x));
      end
      if (capPal[x] != ePal) begin
        badPal++;
        if (badPal == 1) chk("R10", int'(capPal[x]), int'(ePal), $sformatf("%s first palette mismatch dot %0d", tag, x));
      end
    end
    chk("R3", badPix, 0, {tag, " pixel mismatches"});
    chk("R10", badPal, 0, {tag, " palette mismatches"});
    vy = yStep(tA);
    chk("R5", int'({capV[258][14:11], capV[258][9:5]}), int'({vy[14:11], vy[9:5]}), {tag, " vertical step"});
    badRd = 0;
    for (int c = 257; c <= 340; c++) if (capPix[c] != 2'b00 || capPal[c] != 2'b00) badRd++;
    chk("R8", badRd + int'(capPix[0]), 0, {tag, " blank dots"});
  endtask

  task automatic tIdleLine();
    logic [14:0] v0;
    int rd, px;
    renderEn = 1'b1;
    @(negedge clk); v0 = vAddr;
    runLine(245);
    rd = 0; px = 0;
    for (int c = 0; c <= 340; c++) begin
      rd += int'(capRd[c]);
      if (capPix[c] != 2'b00) px++;
    end
    chk("R8", rd, 0, "reads on idle line");
    chk("R8", px, 0, "pixels on idle line");
    chk("R8", int'(capV[340]), int'(v0), "address held on idle line");
  endtask

  task automatic tDisabled();
    logic [14:0] v0;
    int rd, px;
    renderEn = 1'b0;
    tAddr = 15'h5A5A;
    @(negedge clk); v0 = vAddr;
    runLine(0);
    runLine(261);
    rd = 0; px = 0;
    for (int c = 0; c <= 340; c++) begin
      rd += int'(capRd[c]);
      if (capPix[c] != 2'b00 || capPal[c] != 2'b00) px++;
    end
    chk("R9", rd, 0, "reads while disabled");
    chk("R9", px, 0, "pixels while disabled");
    chk("R9", int'(capV[340]), int'(v0), "address held while disabled");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tReset();
    // fine Y 3, coarse Y 5, coarse X 4, no fine scroll
    tScroll({3'd3, 2'b00, 5'd5, 5'd4}, 3'd0, 1'b0, "caseA");
    // column 30 crosses the table edge; row 29 with fine Y 7 wraps and toggles
    tScroll({3'd7, 2'b01, 5'd29, 5'd30}, 3'd5, 1'b1, "caseB");
    // row 31 wraps without toggle; last tap
    tScroll({3'd7, 2'b10, 5'd31, 5'd13}, 3'd7, 1'b0, "caseC");
    tIdleLine();
    tDisabled();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #1000000;
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule